// File: doc/BRIEF.md
# GPIO Port with Change-Detect Interrupt

This block is a memory-mapped general-purpose I/O port with up to 32 pins. Each pin has a direction bit and an output level bit. Each pin input passes through a two-flop synchronizer. A sticky change bit records every rising and every falling edge the pin shows. Software acknowledges a pending change by writing a one to its bit. Change bits that are unmasked by the per-pin enable are ORed onto one interrupt line.

Software reaches the port over a plain 32-bit register interface:

- A write is taken on the clock edge where `wr_en` is high.
- A read is combinational from `addr`.

Two further 32-bit registers hold a write mask and an interrupt type. The port only stores these two values and does not act on them.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0 (all pins inputs) and `irq` is low.
- R2: Byte offset 0x00 holds the direction bits. A 1 in bit i makes pin i an output, driving `pin_oe[i]` high, from the clock edge after the write.
- R3: Writing offset 0x04 sets `pin_out` from the clock edge after the write. Reading offset 0x04 returns the pin input levels, which appear two clock edges after a pin change.
- R4: Bit i of the change register at offset 0x0C is set by both a rising edge and a falling edge on pin i. The bit is readable three clock edges after the pin changes.
- R5: Writing offset 0x0C clears each change bit written as 1. Bits written as 0 keep their value.
- R6: Offset 0x08 holds the per-pin enable. `irq` is high exactly when the bitwise AND of the change bits and the enable bits is nonzero.
- R7: Offsets 0x10 and 0x14 store a full 32-bit value each and read it back.
- R8: In the direction, data, enable and change registers, bits at or above NGPIO read 0 and ignore writes.
- R9: Reads from any offset other than the six mapped ones return 0. Writes to such offsets change no register.
- R10: A pin edge that arrives on the same clock edge as a clearing write to that bit leaves the bit set.
- R11: Change detection runs regardless of direction. Toggling an output pin sets its change bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from addr |
| pin_in | input | NGPIO | Pin levels from the pads |
| pin_out | output | NGPIO | Output levels |
| pin_oe | output | NGPIO | Output enable per pin (1 = output) |
| irq | output | 1 | Combined interrupt |

## Verification
Writes take effect on the clock edge that samples `wr_en`. Register, `pin_oe`, `pin_out` and `irq` results are therefore due one edge after the write, and the bench reads them at the following falling edge. A pin change reaches the data read after two edges and the change register after three. After every pin stimulus the bench waits exactly three rising edges and then samples at a falling edge. The collision test places the clearing write on the third edge, which is the edge that latches the new change.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int NGPIO  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [NGPIO-1:0]  pin_in,
  output logic [NGPIO-1:0]  pin_out,
  output logic [NGPIO-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_DAT  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_IEN  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_CHG  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_WMSK = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_TYPE = ADDR_W'(8'h14);

  logic [NGPIO-1:0] dir_q, out_q, ien_q, chg_q;
  logic [NGPIO-1:0] s1_q, s2_q, prev_q;
  logic [31:0]      wmsk_q, type_q;

  wire [NGPIO-1:0] wbits  = wr_data[NGPIO-1:0];
  wire [NGPIO-1:0] edge_w = s2_q ^ prev_q;
  wire [NGPIO-1:0] ack_w  = (wr_en && addr == OFS_CHG) ? wbits : '0;

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign irq     = |(chg_q & ien_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      chg_q  <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      chg_q  <= (chg_q & ~ack_w) | edge_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      wmsk_q <= '0;
      type_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_DIR:  dir_q  <= wbits;
        OFS_DAT:  out_q  <= wbits;
        OFS_IEN:  ien_q  <= wbits;
        OFS_WMSK: wmsk_q <= wr_data;
        OFS_TYPE: type_q <= wr_data;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_DIR:  rd_data = 32'(dir_q);
      OFS_DAT:  rd_data = 32'(s2_q);
      OFS_IEN:  rd_data = 32'(ien_q);
      OFS_CHG:  rd_data = 32'(chg_q);
      OFS_WMSK: rd_data = wmsk_q;
      OFS_TYPE: rd_data = type_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int NGPIO  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic [NGPIO-1:0]  pin_out,
  input logic [NGPIO-1:0]  pin_oe,
  input logic              irq,
  input logic [NGPIO-1:0]  ien_q,
  input logic [NGPIO-1:0]  chg_q,
  input logic [NGPIO-1:0]  s2_q,
  input logic [NGPIO-1:0]  prev_q
);
  wire mapped = (addr == ADDR_W'(8'h00)) || (addr == ADDR_W'(8'h04)) ||
                (addr == ADDR_W'(8'h08)) || (addr == ADDR_W'(8'h0C)) ||
                (addr == ADDR_W'(8'h10)) || (addr == ADDR_W'(8'h14));
  wire [NGPIO-1:0] seen = s2_q ^ prev_q;

  AST_DIR_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h00)) |=> pin_oe == $past(wr_data[NGPIO-1:0])); // R2
  AST_OUT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h04)) |=> pin_out == $past(wr_data[NGPIO-1:0])); // R3
  AST_EDGE_NEVER_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (|seen) |=> ((chg_q & $past(seen)) == $past(seen))); // R10
  AST_NO_SPURIOUS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg_q & ~$past(chg_q) & ~$past(seen)) == '0)); // R4
  AST_MASKED_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R6
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> rd_data == 32'd0); // R9
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NGPIO(NGPIO), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .ien_q(ien_q), .chg_q(chg_q), .s2_q(s2_q), .prev_q(prev_q)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
  localparam int PERIOD = 10;
  localparam int N = 6;
  localparam logic [31:0] ALL = 32'h3F;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rd;
  logic [N-1:0] ext = 0, pin_in, pin_out, pin_oe;
  logic irq;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_edge_port #(.NGPIO(N), .ADDR_W(8)) i_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wdata),
    .rd_data(rd), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    check(req, rd, exp);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD*100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) rdchk("R1", 8'(a*4), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 oe", 32'(pin_oe), 0);

    // R4 + R5: every pin, both edges, acknowledge per bit
    for (int i = 0; i < N; i++) begin
      for (int e = 0; e < 2; e++) begin
        ext[i] = ~ext[i];
        settle();
        rdchk("R4", 8'h0C, 32'(1) << i);
        rdchk("R3 level", 8'h04, 32'(ext));
        wr(8'h0C, 32'h0);
        rdchk("R5 zero keeps", 8'h0C, 32'(1) << i);
        wr(8'h0C, 32'hFFFF_FFFF);
        rdchk("R5 clear", 8'h0C, 0);
      end
    end

    // R10: new edge on the same edge as a clearing write
    ext[2] = 1; settle();
    ext[2] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(8'h0C, 32'h04);
    rdchk("R10", 8'h0C, 32'h04);
    wr(8'h0C, 32'h04);
    rdchk("R10 cleared", 8'h0C, 0);

    // R6: sweep all enable masks against a partial change pattern
    ext = 6'h3F; settle();
    wr(8'h0C, 32'h2A);
    rdchk("R6 pattern", 8'h0C, 32'h15);
    for (int m = 0; m < 64; m++) begin
      wr(8'h08, 32'(m) | 32'hFFFF_FFC0);
      check("R6 irq", 32'(irq), 32'(((m & 32'h15) != 0) ? 1 : 0));
    end
    rdchk("R8 ien", 8'h08, ALL);
    wr(8'h08, 0);
    wr(8'h0C, ALL);

    // R2 / R3 / R11: outputs and loopback
    wr(8'h04, ALL);
    wr(8'h00, 32'hFFFF_FFFF);
    check("R2 oe", 32'(pin_oe), ALL);
    rdchk("R8 dir", 8'h00, ALL);
    settle();
    rdchk("R11 quiet", 8'h0C, 0);
    wr(8'h04, 32'hFFFF_FF05);
    check("R3 out", 32'(pin_out), 32'h05);
    settle();
    rdchk("R3 data", 8'h04, 32'h05);
    rdchk("R11 change", 8'h0C, 32'h3A);
    wr(8'h0C, ALL);

    // R7 plain storage
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h14, 32'h1234_5678);
    rdchk("R7 wmask", 8'h10, 32'hDEAD_BEEF);
    rdchk("R7 type", 8'h14, 32'h1234_5678);

    // R9 unmapped offsets
    wr(8'h18, 0); wr(8'h40, 0); wr(8'h01, 0);
    rdchk("R9 read", 8'h18, 0);
    rdchk("R9 read", 8'hFC, 0);
    rdchk("R9 dir kept", 8'h00, ALL);
    rdchk("R9 out kept", 8'h04, 32'h05);
    rdchk("R9 type kept", 8'h14, 32'h1234_5678);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule